// File: doc/BRIEF.md
# Single-Pin GPIO Control Cell

This cell holds the complete control logic for one general-purpose I/O pin. A single 32-bit configuration word sets the pin's direction, its interrupt trigger type, a peripheral function select, the pull setting, the input enable and the interrupt group. When the pin is an output, the data bit drives the pad. When the pin is an input, the pad signal passes through a synchroniser. The synchronised value feeds both the readback path and the trigger detector.

Direction and trigger type share one 3-bit mode field. To mask the pin's interrupt, software rewrites that field to the "input, quiet" code. The trigger detector is a four-state machine:

- `IRQ_DISARMED`: no trigger mode is selected.
- `IRQ_ARMED`: a trigger mode is selected and no condition is present.
- `IRQ_LEVEL_ON`: the selected level is present on the pin.
- `IRQ_EDGE_HELD`: a sticky edge capture is waiting.

The state machine takes these transitions:

- **arm**: from `IRQ_DISARMED`, a trigger mode is selected.
- **level hit**: the selected level is seen; the machine enters `IRQ_LEVEL_ON`.
- **level gone**: the level goes away; the machine returns to `IRQ_ARMED`.
- **edge hit**: the selected edge is seen; the machine enters `IRQ_EDGE_HELD`.
- **clear**: a clear pulse arrives with no new edge; the machine leaves `IRQ_EDGE_HELD`.
- **disarm**: from any state, the mode becomes non-trigger.

The pending output goes to a group status bank. The bank acknowledges an edge capture with a one-cycle clear pulse.

A lock bit freezes the configuration. While it is set, only the data bit can still be written.

Top module: `gpio_pin_cell`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x0000000E (mode 7, all other fields 0, pad low). `irq_pend` and `pad_oe` are 0.
- R2: With function 0 and mode 1 (output), `pad_oe` is 1 and `pad_out` equals the stored data bit 0. Readback bit 0 returns the stored bit.
- R3: In every mode other than 1, readback bit 0 is the pad value delayed by two clock edges. With function 0, `pad_oe` is 0.
- R4: Mode 2 (level high) and mode 3 (level low) hold `irq_pend` at 1 while the level holds. `irq_pend` returns to 0 once the level goes away. `irq_clr` has no effect in these modes.
- R5: Mode 4 (rising), mode 5 (falling) and mode 6 (either edge) set `irq_pend` on the matching edge. `irq_pend` stays 1 until an `irq_clr` pulse.
- R6: If `irq_clr` arrives in the same cycle that a new matching edge is detected, `irq_pend` stays 1.
- R7: Modes 7 and 0 never raise `irq_pend`. Writing mode 7 drops a pending request one cycle after the write, and leaves the pull, enable and group fields as written.
- R8: Bits 6:5 select the function. With function f in 1..3, `pad_out` and `pad_oe` come from lane f-1 of `periph_out` and `periph_oe`, and `periph_din` carries the synchronised pad value. With function 0, `periph_din` is 0.
- R9: Bits 8:7 appear on `pad_pull`, bit 9 appears on `pad_ie`, and bits 18:16 appear on `irq_grp`.
- R10: While bit 21 (lock) is set, a write changes only bit 0. The lock bit itself cannot be cleared until reset.
- R11: Bits 4, 15:10, 20:19 and 31:22 always read as 0.
- R12: A pad change that meets the trigger condition raises `irq_pend` on the third clock edge after it, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback; bit 0 is live in input modes |
| pad_in | input | 1 | Asynchronous pad input |
| pad_out | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad output enable |
| pad_pull | output | 2 | Pull select (0 none, 1 down, 2 strong up, 3 up) |
| pad_ie | output | 1 | Pad input enable |
| periph_out | input | 3 | Output values from the three peripheral functions |
| periph_oe | input | 3 | Output enables from the three peripheral functions |
| periph_din | output | 1 | Synchronised pad value to the selected peripheral |
| irq_grp | output | 3 | Interrupt group number |
| irq_pend | output | 1 | Pending interrupt request |
| irq_clr | input | 1 | One-cycle clear from the group status bank |

## Verification
The bench first checks trigger latency. It tests that the request appears exactly on the third edge after a pad change. A cell with one synchroniser stage too few or too many fails this timing check.

It then checks three trigger corner cases:

- A clear pulse that coincides with a new edge. A design that lets the clear win would lose that interrupt.
- A clear pulse sent in a level mode. A design that honoured it would drop a request whose level still holds.
- A rewrite of the mode to 7 while an edge is pending. The request must drop and must not come back when the pad toggles.

The lock test writes a full word after locking. A cell that honoured that write, or let the lock be cleared, shows the wrong mode on the readback or the wrong value on `pad_out`.

// File: rtl/gpio_cell_pkg.sv
package gpio_cell_pkg;

    localparam int WORD_W    = 32;
    localparam int MODE_W    = 3;
    localparam int FUNC_W    = 2;
    localparam int PULL_W    = 2;
    localparam int GRP_W     = 3;

    localparam int DATA_POS  = 0;
    localparam int MODE_LSB  = 1;
    localparam int FUNC_LSB  = 5;
    localparam int PULL_LSB  = 7;
    localparam int IE_POS    = 9;
    localparam int GRP_LSB   = 16;
    localparam int LOCK_POS  = 21;

    typedef enum logic [MODE_W-1:0] {
        MD_RSVD     = 3'd0,
        MD_OUT      = 3'd1,
        MD_LVL_HI   = 3'd2,
        MD_LVL_LO   = 3'd3,
        MD_RISE     = 3'd4,
        MD_FALL     = 3'd5,
        MD_ANY      = 3'd6,
        MD_IN_QUIET = 3'd7
    } pin_mode_e;

    typedef enum logic [1:0] {
        IRQ_DISARMED  = 2'd0,
        IRQ_ARMED     = 2'd1,
        IRQ_LEVEL_ON  = 2'd2,
        IRQ_EDGE_HELD = 2'd3
    } irq_state_e;

    typedef struct packed {
        logic             lock;
        logic [GRP_W-1:0] grp;
        logic             ie;
        logic [PULL_W-1:0] pull;
        logic [FUNC_W-1:0] func;
        pin_mode_e        mode;
        logic             data;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{
        lock: 1'b0, grp: '0, ie: 1'b0, pull: '0, func: '0,
        mode: MD_IN_QUIET, data: 1'b0
    };

    function automatic pin_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        pin_cfg_t c;
        c.data = w[DATA_POS];
        c.mode = pin_mode_e'(w[MODE_LSB +: MODE_W]);
        c.func = w[FUNC_LSB +: FUNC_W];
        c.pull = w[PULL_LSB +: PULL_W];
        c.ie   = w[IE_POS];
        c.grp  = w[GRP_LSB +: GRP_W];
        c.lock = w[LOCK_POS];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input pin_cfg_t c, input logic bit0);
        logic [WORD_W-1:0] w;
        w = '0;
        w[DATA_POS]               = bit0;
        w[MODE_LSB +: MODE_W]     = c.mode;
        w[FUNC_LSB +: FUNC_W]     = c.func;
        w[PULL_LSB +: PULL_W]     = c.pull;
        w[IE_POS]                 = c.ie;
        w[GRP_LSB +: GRP_W]       = c.grp;
        w[LOCK_POS]               = c.lock;
        return w;
    endfunction

    function automatic logic mode_is_trigger(input pin_mode_e m);
        return (m == MD_LVL_HI) || (m == MD_LVL_LO) || (m == MD_RISE) ||
               (m == MD_FALL) || (m == MD_ANY);
    endfunction

endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
    import gpio_cell_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output pin_cfg_t     cfg
);
    pin_cfg_t cfg_q;
    pin_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (cfg_q.lock) begin
                cfg_d.data = wdata[DATA_POS];
            end else begin
                cfg_d = word_to_cfg(wdata);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_async,
    output logic sync_q,
    output logic prev_q
);
    localparam int CHAIN = (STAGES < 2) ? 2 : STAGES;

    logic [CHAIN-1:0] chain_q;
    logic             hist_q;

    genvar gi;
    generate
        for (gi = 0; gi < CHAIN; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= pad_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= chain_q[CHAIN-1];
    end

    assign sync_q = chain_q[CHAIN-1];
    assign prev_q = hist_q;
endmodule

// File: rtl/gpio_irq_fsm.sv
module gpio_irq_fsm
    import gpio_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      sync_in,
    input  logic      prev_in,
    input  logic      clr,
    output logic      pend
);
    irq_state_e state_q;
    irq_state_e state_d;

    logic trig;
    logic rise;
    logic fall;
    logic lvl_hit;
    logic edge_hit;

    always_comb begin
        trig     = mode_is_trigger(mode);
        rise     = sync_in & ~prev_in;
        fall     = ~sync_in & prev_in;
        lvl_hit  = ((mode == MD_LVL_HI) & sync_in) |
                   ((mode == MD_LVL_LO) & ~sync_in);
        edge_hit = ((mode == MD_RISE) & rise) |
                   ((mode == MD_FALL) & fall) |
                   ((mode == MD_ANY)  & (rise | fall));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_DISARMED, IRQ_ARMED: begin
                if (!trig)          state_d = IRQ_DISARMED;
                else if (lvl_hit)   state_d = IRQ_LEVEL_ON;
                else if (edge_hit)  state_d = IRQ_EDGE_HELD;
                else                state_d = IRQ_ARMED;
            end
            IRQ_LEVEL_ON: begin
                if (!trig)          state_d = IRQ_DISARMED;
                else if (lvl_hit)   state_d = IRQ_LEVEL_ON;
                else if (edge_hit)  state_d = IRQ_EDGE_HELD;
                else                state_d = IRQ_ARMED;
            end
            IRQ_EDGE_HELD: begin
                if (!trig)                 state_d = IRQ_DISARMED;
                else if (clr && !edge_hit) state_d = lvl_hit ? IRQ_LEVEL_ON : IRQ_ARMED;
                else                       state_d = IRQ_EDGE_HELD;
            end
            default:                       state_d = IRQ_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        pend = (state_q == IRQ_LEVEL_ON) || (state_q == IRQ_EDGE_HELD);
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_cell_pkg::*;
#(
    parameter int NFUNC = 3
) (
    input  logic [FUNC_W-1:0] func,
    input  pin_mode_e         mode,
    input  logic              data,
    input  logic              sync_in,
    input  logic [NFUNC-1:0]  periph_out,
    input  logic [NFUNC-1:0]  periph_oe,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              periph_din
);
    logic [NFUNC:0] lane_out;
    logic [NFUNC:0] lane_oe;

    assign lane_out[0] = data;
    assign lane_oe[0]  = (mode == MD_OUT);

    genvar gl;
    generate
        for (gl = 1; gl <= NFUNC; gl++) begin : g_lane
            assign lane_out[gl] = periph_out[gl-1];
            assign lane_oe[gl]  = periph_oe[gl-1];
        end
    endgenerate

    always_comb begin
        if (int'(func) <= NFUNC) begin
            pad_out = lane_out[func];
            pad_oe  = lane_oe[func];
        end else begin
            pad_out = 1'b0;
            pad_oe  = 1'b0;
        end
        periph_din = (func != '0) & sync_in;
    end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_cell_pkg::*;
#(
    parameter int NFUNC       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [WORD_W-1:0]   cfg_wdata,
    output logic [WORD_W-1:0]   cfg_rdata,
    input  logic                pad_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic [PULL_W-1:0]   pad_pull,
    output logic                pad_ie,
    input  logic [NFUNC-1:0]    periph_out,
    input  logic [NFUNC-1:0]    periph_oe,
    output logic                periph_din,
    output logic [GRP_W-1:0]    irq_grp,
    output logic                irq_pend,
    input  logic                irq_clr
);
    pin_cfg_t cfg;
    logic     pad_sync;
    logic     pad_prev;

    gpio_cfg_reg #(.W(WORD_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_async (pad_in),
        .sync_q    (pad_sync),
        .prev_q    (pad_prev)
    );

    gpio_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (cfg.mode),
        .sync_in (pad_sync),
        .prev_in (pad_prev),
        .clr     (irq_clr),
        .pend    (irq_pend)
    );

    gpio_pad_mux #(.NFUNC(NFUNC)) u_mux (
        .func       (cfg.func),
        .mode       (cfg.mode),
        .data       (cfg.data),
        .sync_in    (pad_sync),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .periph_din (periph_din)
    );

    assign cfg_rdata = cfg_to_word(cfg, (cfg.mode == MD_OUT) ? cfg.data : pad_sync);
    assign pad_pull  = cfg.pull;
    assign pad_ie    = cfg.ie;
    assign irq_grp   = cfg.grp;
endmodule

// File: rtl/gpio_pin_cell_chk.sv
module gpio_pin_cell_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [31:0] cfg_rdata,
    input logic        pad_out,
    input logic        pad_oe,
    input logic [1:0]  pad_pull,
    input logic        pad_ie,
    input logic [2:0]  irq_grp,
    input logic        irq_pend,
    input logic        irq_clr
);
    localparam logic [31:0] RSVD_MASK = 32'hFFD8_FC10;

    logic [2:0] md;
    logic       md_trig;
    logic       md_edge;
    assign md      = cfg_rdata[3:1];
    assign md_trig = (md >= 3'd2) && (md <= 3'd6);
    assign md_edge = (md >= 3'd4) && (md <= 3'd6);

    AST_QUIET_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !md_trig |=> !irq_pend);                                            // R7

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && md_edge && ($past(md) >= 3'd4) && ($past(md) <= 3'd6) && !irq_clr)
        |=> irq_pend);                                                      // R5

    AST_OUT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[6:5] == 2'd0 && md == 3'd1) |-> (pad_oe && pad_out == cfg_rdata[0])); // R2

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & RSVD_MASK) == 32'd0);                                  // R11

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[21] |=> cfg_rdata[21]);                                   // R10

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[21] && cfg_we) |=> (cfg_rdata[31:1] == $past(cfg_rdata[31:1]))); // R10

    AST_FIELD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull == cfg_rdata[8:7]) && (pad_ie == cfg_rdata[9]) && (irq_grp == cfg_rdata[18:16])); // R9
endmodule

bind gpio_pin_cell gpio_pin_cell_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_rdata (cfg_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pull  (pad_pull),
    .pad_ie    (pad_ie),
    .irq_grp   (irq_grp),
    .irq_pend  (irq_pend),
    .irq_clr   (irq_clr)
);

// File: tb/gpio_pin_cell_bench.sv
module gpio_pin_cell_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pad_in = 1'b0;
    logic        pad_out;
    logic        pad_oe;
    logic [1:0]  pad_pull;
    logic        pad_ie;
    logic [2:0]  periph_out = 3'b000;
    logic [2:0]  periph_oe = 3'b000;
    logic        periph_din;
    logic [2:0]  irq_grp;
    logic        irq_pend;
    logic        irq_clr = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    gpio_pin_cell u_gpio_pin_cell (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull(pad_pull), .pad_ie(pad_ie), .periph_out(periph_out),
        .periph_oe(periph_oe), .periph_din(periph_din), .irq_grp(irq_grp),
        .irq_pend(irq_pend), .irq_clr(irq_clr)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog: run hung act=%0d exp<=20000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1;
        step(1);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pad_in = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset word", cfg_rdata, 32'h0000_000E);
        chk("R1 reset pend", {31'd0, irq_pend}, 32'd0);
        chk("R1 reset oe", {31'd0, pad_oe}, 32'd0);
    endtask

    task automatic t_output();
        wr(32'h0000_0003);
        chk("R2 oe", {31'd0, pad_oe}, 32'd1);
        chk("R2 out high", {31'd0, pad_out}, 32'd1);
        pad_in = 1'b0;
        step(3);
        chk("R2 readback stored bit", {31'd0, cfg_rdata[0]}, 32'd1);
        wr(32'h0000_0002);
        chk("R2 out low", {31'd0, pad_out}, 32'd0);
    endtask

    task automatic t_input_sync();
        wr(32'h0000_000E);
        chk("R3 oe off", {31'd0, pad_oe}, 32'd0);
        step(3);
        pad_in = 1'b1;
        step(1);
        chk("R3 one edge still old", {31'd0, cfg_rdata[0]}, 32'd0);
        step(1);
        chk("R3 two edges live", {31'd0, cfg_rdata[0]}, 32'd1);
        pad_in = 1'b0;
        step(3);
    endtask

    task automatic t_level();
        wr(32'h0000_0004);
        step(2);
        chk("R4 hi idle", {31'd0, irq_pend}, 32'd0);
        pad_in = 1'b1;
        step(2);
        chk("R12 not on second edge", {31'd0, irq_pend}, 32'd0);
        step(1);
        chk("R12 level on third edge", {31'd0, irq_pend}, 32'd1);
        pulse_clr();
        step(1);
        chk("R4 clr ignored in level", {31'd0, irq_pend}, 32'd1);
        pad_in = 1'b0;
        step(3);
        chk("R4 level gone", {31'd0, irq_pend}, 32'd0);
        wr(32'h0000_0006);
        step(1);
        chk("R4 level low", {31'd0, irq_pend}, 32'd1);
        wr(32'h0000_000E);
        step(1);
    endtask

    task automatic t_edge();
        wr(32'h0000_0008);
        step(3);
        pad_in = 1'b1;
        step(2);
        chk("R12 edge not on second", {31'd0, irq_pend}, 32'd0);
        step(1);
        chk("R5 rise pend", {31'd0, irq_pend}, 32'd1);
        pad_in = 1'b0;
        step(4);
        chk("R5 sticky", {31'd0, irq_pend}, 32'd1);
        pulse_clr();
        chk("R5 cleared", {31'd0, irq_pend}, 32'd0);
        wr(32'h0000_000A);
        pad_in = 1'b1;
        step(4);
        chk("R5 fall ignores rise", {31'd0, irq_pend}, 32'd0);
        pad_in = 1'b0;
        step(3);
        chk("R5 fall pend", {31'd0, irq_pend}, 32'd1);
        pulse_clr();
        wr(32'h0000_000C);
        pad_in = 1'b1;
        step(3);
        chk("R5 any rise", {31'd0, irq_pend}, 32'd1);
        pulse_clr();
        pad_in = 1'b0;
        step(3);
        chk("R5 any fall", {31'd0, irq_pend}, 32'd1);
        pulse_clr();
        chk("R5 any cleared", {31'd0, irq_pend}, 32'd0);
    endtask

    task automatic t_collision();
        wr(32'h0000_0008);
        step(2);
        pad_in = 1'b1;
        step(3);
        pad_in = 1'b0;
        step(3);
        chk("R6 held before", {31'd0, irq_pend}, 32'd1);
        pad_in = 1'b1;
        step(2);
        pulse_clr();
        chk("R6 edge beats clr", {31'd0, irq_pend}, 32'd1);
        pulse_clr();
        chk("R6 later clr", {31'd0, irq_pend}, 32'd0);
        pad_in = 1'b0;
        step(3);
    endtask

    task automatic t_disable();
        wr(32'h0000_0008);
        step(2);
        pad_in = 1'b1;
        step(3);
        chk("R7 pending before", {31'd0, irq_pend}, 32'd1);
        wr(32'h0003_030E);
        step(1);
        chk("R7 dropped", {31'd0, irq_pend}, 32'd0);
        chk("R7 fields kept", {29'd0, pad_pull, pad_ie}, 32'd5);
        chk("R7 grp kept", {29'd0, irq_grp}, 32'd3);
        pad_in = 1'b0;
        step(3);
        pad_in = 1'b1;
        step(3);
        chk("R7 quiet mode 7", {31'd0, irq_pend}, 32'd0);
        wr(32'h0000_0000);
        pad_in = 1'b0;
        step(3);
        chk("R7 quiet mode 0", {31'd0, irq_pend}, 32'd0);
        chk("R3 mode 0 live", {31'd0, cfg_rdata[0]}, 32'd0);
    endtask

    task automatic t_periph();
        periph_out = 3'b101; periph_oe = 3'b011;
        wr(32'h0000_0003);
        chk("R8 func0 periph_din", {31'd0, periph_din}, 32'd0);
        wr(32'h0000_002E);
        chk("R8 f1", {30'd0, pad_oe, pad_out}, 32'd3);
        wr(32'h0000_004E);
        chk("R8 f2", {30'd0, pad_oe, pad_out}, 32'd2);
        wr(32'h0000_006E);
        chk("R8 f3", {30'd0, pad_oe, pad_out}, 32'd1);
        pad_in = 1'b1;
        step(2);
        chk("R8 periph_din", {31'd0, periph_din}, 32'd1);
    endtask

    task automatic t_fields();
        pad_in = 1'b0;
        wr(32'h0005_038E);
        step(2);
        chk("R9 pull", {30'd0, pad_pull}, 32'd3);
        chk("R9 ie", {31'd0, pad_ie}, 32'd1);
        chk("R9 grp", {29'd0, irq_grp}, 32'd5);
        chk("R9 word", cfg_rdata, 32'h0005_038E);
        pad_in = 1'b1;
        wr(32'hFFDF_FFFF);
        step(2);
        chk("R11 reserved zero", cfg_rdata, 32'h0007_03EF);
    endtask

    task automatic t_lock();
        wr(32'h0020_0003);
        chk("R10 locked word", cfg_rdata, 32'h0020_0003);
        wr(32'h0000_000E);
        chk("R10 only data bit", cfg_rdata, 32'h0020_0002);
        chk("R10 pad follows data", {30'd0, pad_oe, pad_out}, 32'd2);
        wr(32'h0000_0001);
        chk("R10 lock kept", cfg_rdata, 32'h0020_0003);
    endtask

    initial begin
        t_reset();
        t_output();
        t_input_sync();
        t_level();
        t_edge();
        t_collision();
        t_disable();
        t_periph();
        t_fields();
        t_lock();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule